// File: doc/BRIEF.md
# Nonuniform Piecewise-Linear Sine Synthesizer

The block is a direct digital synthesizer. A phase register adds a frequency word on every clock, and its upper bits are turned into a signed sine sample. Only the first quarter of the wave is modelled, as a chain of straight-line pieces. The two top phase bits fold the phase back into that quarter and restore the sign, which rebuilds a whole period.

The pieces have different lengths, and every length is a power of two. The piece that applies to a phase is therefore found by matching a short prefix of its leading bits, and the prefix length differs from piece to piece. Inside a piece there is no multiplier. The slope is formed as a signed sum of a few shifted copies of the distance into the piece, and the piece's start value is then added. A constant table in the package holds every piece's prefix, start value and shift terms. The amplitude comes out of one register.

The user sets the output frequency with the frequency word. The output resolution and the phase widths are parameters. The default table targets a 12-bit output with a 10-bit quarter-wave index, and wider outputs scale that table.

Top module: `pwl_sine_ddfs`

## Requirements
- R1: While `rst` is high at a rising edge, the phase register and `amp` both become 0 on that edge.
- R2: On every edge without reset, the phase register becomes (phase + `fcw`) modulo 2^PHASE_W. The phase wraps silently, and the fraction bits below the mapper window carry into it.
- R3: `amp` after an edge is the mapping of the phase value that was held before that edge. The path from phase to amplitude has exactly one register.
- R4: With the defaults (AMP_W=12, 10-bit quarter index x, d = x minus the piece start), the magnitude is:
  - x in [0,256): 0 + (4d) - (4d>>2)
  - [256,512): 783 + (4d>>1) + (4d>>3)
  - [512,768): 1447 + (4d>>1) - (4d>>4)
  - [768,896): 1891 + (4d>>2) - (4d>>6)
  - [896,960): 2008 + (4d>>3) - (4d>>6)
  - [960,1024): 2037 + (4d>>5) + (4d>>7)
- R5: The pieces are chosen by the leading bits of x, with prefixes 00, 01, 10, 110, 1110 and 1111 in the order of R4. Exactly one piece matches any x, and the longest matching prefix wins.
- R6: The magnitude never exceeds 2^(AMP_W-1)-1. At the defaults it peaks at 2045, so `amp` spans -2045 to 2045.
- R7: The top two phase bits are the quadrant, and the next 10 bits are p.
  - In quadrants 1 and 3, x is the bitwise inverse of p. Otherwise x = p.
  - In quadrants 2 and 3 (top bit set), the output is the two's-complement negation of the magnitude.
- R8: With `fcw` = 0, the phase holds, and `amp` stays constant from the second edge onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fcw | input | PHASE_W | Frequency word added to the phase every clock |
| amp | output | AMP_W | Registered signed sine sample, two's complement |

## Verification
The hardest condition to reach from the ports is having every mapper code reach the decoder. That includes the narrow 64-code pieces at the top of the quarter, each under both the plain and the mirrored fold and under both signs. Every code also has to land exactly on the boundaries where the prefix length changes. The bench drives a frequency word of 2^(PHASE_W-MAP_W), so the mapper index advances by exactly one code per clock and sweeps the whole period. It then adds odd, near-wrapping and quarter-period words, plus a mid-run reset, to exercise the carries and the folding.

// File: rtl/pwl_sine_pkg.sv
package pwl_sine_pkg;

  localparam int NSEG   = 6;   // pieces in the quarter wave
  localparam int NTERM  = 2;   // shift-add terms per slope
  localparam int PFX_W  = 4;   // longest prefix length
  localparam int LEN_W  = 3;
  localparam int RSH_W  = 4;
  localparam int BASE_W = 12;
  localparam int REF_QW = 10;  // quarter index width the table is tuned for
  localparam int REF_AW = 12;  // output width the table is tuned for
  localparam int FRAC   = 2;   // slope fraction pre-scale (term = 4d >> r)
  localparam int SEL_W  = $clog2(NSEG);

  typedef enum logic [1:0] {
    TERM_OFF = 2'd0,
    TERM_ADD = 2'd1,
    TERM_SUB = 2'd2
  } term_op_e;

  typedef struct packed {
    term_op_e         op;
    logic [RSH_W-1:0] rsh;
  } term_t;

  typedef struct packed {
    logic [PFX_W-1:0]  pfx;
    logic [LEN_W-1:0]  len;
    logic [BASE_W-1:0] base;
    term_t [NTERM-1:0] terms;
  } seg_t;

  localparam seg_t SEG_TAB [NSEG] = '{
    '{pfx: 4'd0,  len: 3'd2, base: 12'd0,
      terms: '{'{TERM_SUB, 4'd2}, '{TERM_ADD, 4'd0}}},
    '{pfx: 4'd1,  len: 3'd2, base: 12'd783,
      terms: '{'{TERM_ADD, 4'd3}, '{TERM_ADD, 4'd1}}},
    '{pfx: 4'd2,  len: 3'd2, base: 12'd1447,
      terms: '{'{TERM_SUB, 4'd4}, '{TERM_ADD, 4'd1}}},
    '{pfx: 4'd6,  len: 3'd3, base: 12'd1891,
      terms: '{'{TERM_SUB, 4'd6}, '{TERM_ADD, 4'd2}}},
    '{pfx: 4'd14, len: 3'd4, base: 12'd2008,
      terms: '{'{TERM_SUB, 4'd6}, '{TERM_ADD, 4'd3}}},
    '{pfx: 4'd15, len: 3'd4, base: 12'd2037,
      terms: '{'{TERM_ADD, 4'd7}, '{TERM_ADD, 4'd5}}}
  };

endpackage

// File: rtl/pwl_phase_acc.sv
module pwl_phase_acc #(
  parameter int PHASE_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] fcw,
  output logic [PHASE_W-1:0] phase
);

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= phase + fcw;
  end

endmodule

// File: rtl/pwl_seg_decode.sv
module pwl_seg_decode
  import pwl_sine_pkg::*;
(
  input  logic [PFX_W-1:0] lead,
  output logic [NSEG-1:0]  hit,
  output logic [SEL_W-1:0] sel
);

  for (genvar g = 0; g < NSEG; g++) begin : g_match
    localparam int LEN_G = int'(SEG_TAB[g].len);
    assign hit[g] = (lead[PFX_W-1 -: LEN_G] == SEG_TAB[g].pfx[LEN_G-1:0]);
  end

  // longest matching prefix wins
  always_comb begin
    logic [LEN_W-1:0] best_len;
    best_len = '0;
    sel      = '0;
    for (int g = 0; g < NSEG; g++) begin
      if (hit[g] && (SEG_TAB[g].len > best_len)) begin
        best_len = SEG_TAB[g].len;
        sel      = SEL_W'(g);
      end
    end
  end

endmodule

// File: rtl/pwl_slope_eval.sv
module pwl_slope_eval
  import pwl_sine_pkg::*;
#(
  parameter int QW    = 10,
  parameter int AMP_W = 12
) (
  input  logic [QW-1:0]    x,
  input  logic [SEL_W-1:0] sel,
  output logic [AMP_W-2:0] mag
);

  localparam int LS  = FRAC + AMP_W - REF_AW;
  localparam int RS0 = QW - REF_QW;
  localparam int WW  = QW + LS;
  localparam int SW  = AMP_W + 1;

  logic [LEN_W-1:0]  cur_len;
  logic [BASE_W-1:0] cur_base;
  term_t [NTERM-1:0] cur_terms;
  logic [QW-1:0]     d;
  logic [WW-1:0]     wide;
  logic signed [SW-1:0] contrib [NTERM];
  logic signed [SW-1:0] sum;

  always_comb begin
    cur_len   = SEG_TAB[0].len;
    cur_base  = SEG_TAB[0].base;
    cur_terms = SEG_TAB[0].terms;
    for (int g = 1; g < NSEG; g++) begin
      if (sel == SEL_W'(g)) begin
        cur_len   = SEG_TAB[g].len;
        cur_base  = SEG_TAB[g].base;
        cur_terms = SEG_TAB[g].terms;
      end
    end
  end

  // distance into the piece: drop the prefix bits
  assign d    = x & ((QW'(1) << (QW - int'(cur_len))) - QW'(1));
  assign wide = WW'(d) << LS;

  for (genvar t = 0; t < NTERM; t++) begin : g_term
    logic [WW-1:0] shifted;
    assign shifted = wide >> (int'(cur_terms[t].rsh) + RS0);
    always_comb begin
      unique case (cur_terms[t].op)
        TERM_ADD: contrib[t] = $signed(SW'(shifted));
        TERM_SUB: contrib[t] = -$signed(SW'(shifted));
        default:  contrib[t] = '0;
      endcase
    end
  end

  always_comb begin
    sum = $signed(SW'(cur_base) << (AMP_W - REF_AW));
    for (int t = 0; t < NTERM; t++) sum = sum + contrib[t];
  end

  assign mag = sum[AMP_W-2:0];

endmodule

// File: rtl/pwl_sine_ddfs.sv
module pwl_sine_ddfs
  import pwl_sine_pkg::*;
#(
  parameter int PHASE_W = 16,
  parameter int MAP_W   = 12,
  parameter int AMP_W   = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PHASE_W-1:0]      fcw,
  output logic signed [AMP_W-1:0] amp
);

  localparam int QW = MAP_W - 2;

  logic [PHASE_W-1:0] acc;
  logic [1:0]         quad;
  logic [QW-1:0]      pq;
  logic [QW-1:0]      x;
  logic [NSEG-1:0]    hit;
  logic [SEL_W-1:0]   sel;
  logic [AMP_W-2:0]   mag;
  logic signed [AMP_W-1:0] mag_s;
  logic signed [AMP_W-1:0] amp_n;

  pwl_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .fcw   (fcw),
    .phase (acc)
  );

  // quadrant fold: mirror odd quadrants, negate the upper half
  assign quad = acc[PHASE_W-1 -: 2];
  assign pq   = acc[PHASE_W-3 -: QW];
  assign x    = quad[0] ? ~pq : pq;

  pwl_seg_decode u_dec (
    .lead (x[QW-1 -: PFX_W]),
    .hit  (hit),
    .sel  (sel)
  );

  pwl_slope_eval #(.QW(QW), .AMP_W(AMP_W)) u_eval (
    .x   (x),
    .sel (sel),
    .mag (mag)
  );

  assign mag_s = $signed({1'b0, mag});
  assign amp_n = quad[1] ? -mag_s : mag_s;

  always_ff @(posedge clk) begin
    if (rst) amp <= '0;
    else     amp <= amp_n;
  end

  // R1: both registers cleared after a reset edge
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (amp == '0 && acc == '0));

  // R2: phase advances by the frequency word
  a_r2_acc_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> acc == $past(acc + fcw));

  // R5: exactly one piece matches
  a_r5_one_piece: assert property (@(posedge clk) disable iff (rst)
    $onehot(hit));

  // R6: most negative code never produced
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    amp != {1'b1, {(AMP_W-1){1'b0}}});

  // R7: sign follows the upper-half bit of the previous phase
  a_r7_sign_half: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && amp != '0) |-> amp[AMP_W-1] == $past(acc[PHASE_W-1]));

  // R8: a held phase gives a held sample
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fcw) == '0 && $stable(acc)) |=> $stable(amp));

endmodule

// File: tb/tb_pwl_sine_ddfs.sv
`timescale 1ns/1ps
module tb_pwl_sine_ddfs;

  localparam int PW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PW-1:0] fcw = '0;
  logic signed [11:0] amp;

  int errors = 0;
  int checks = 0;
  int acc_m  = 0;
  int seen_max = -100000;
  int seen_min = 100000;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  pwl_sine_ddfs dut (.clk(clk), .rst(rst), .fcw(fcw), .amp(amp));

  function automatic int ref_mag(int x);
    int d;
    if (x < 256)      begin d = x;       return 0    + (4*d)      - ((4*d)>>2); end
    else if (x < 512) begin d = x - 256; return 783  + ((4*d)>>1) + ((4*d)>>3); end
    else if (x < 768) begin d = x - 512; return 1447 + ((4*d)>>1) - ((4*d)>>4); end
    else if (x < 896) begin d = x - 768; return 1891 + ((4*d)>>2) - ((4*d)>>6); end
    else if (x < 960) begin d = x - 896; return 2008 + ((4*d)>>3) - ((4*d)>>6); end
    else              begin d = x - 960; return 2037 + ((4*d)>>5) + ((4*d)>>7); end
  endfunction

  function automatic int ref_amp(int ph);
    int q, p, x, m;
    q = (ph >> 14) & 3;
    p = (ph >> 4) & 1023;
    x = (q % 2 == 1) ? 1023 - p : p;
    m = ref_mag(x);
    return (q >= 2) ? -m : m;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock, model advanced and compared (R3 R4 R5 R7)
  task automatic step(string req);
    int e;
    @(negedge clk);
    e = ref_amp(acc_m);
    acc_m = (acc_m + int'(fcw)) & 32'hFFFF;
    chk(int'(amp) == e, req, int'(amp), e);
    if (int'(amp) > seen_max) seen_max = int'(amp);
    if (int'(amp) < seen_min) seen_min = int'(amp);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(amp == 0, "R1 reset", int'(amp), 0);
    acc_m = 0;
    rst = 1'b0;
  endtask

  initial begin
    int held;
    do_reset();

    // exhaustive sweep: one mapper code per clock
    fcw = 16'h0010;
    for (int i = 0; i < 4100; i++) step("R4 R5 R3 sweep");
    chk(seen_max == 2045, "R6 peak", seen_max, 2045);
    chk(seen_min == -2045, "R6 R7 trough", seen_min, -2045);

    // hold with zero frequency word
    fcw = '0;
    step("R8 first");
    held = int'(amp);
    for (int i = 0; i < 12; i++) begin
      step("R8 model");
      chk(int'(amp) == held, "R8 hold", int'(amp), held);
    end

    // odd word, fraction carries and wraps
    fcw = 16'h9A37;
    for (int i = 0; i < 3000; i++) step("R2 odd word");

    // mid-run reset, then descending phase
    do_reset();
    fcw = 16'hFFF0;
    for (int i = 0; i < 1500; i++) step("R2 R7 descending");

    // quadrant jumps from zero
    do_reset();
    fcw = 16'h4000;
    step("R7 q0");
    chk(amp == 0, "R7 q0 start", int'(amp), 0);
    step("R7 q1");
    chk(int'(amp) == 2045, "R7 q1 mirror", int'(amp), 2045);
    step("R7 q2");
    chk(amp == 0, "R7 q2 zero", int'(amp), 0);
    step("R7 q3");
    chk(int'(amp) == -2045, "R7 q3 negate", int'(amp), -2045);

    // reset asserted while running clears output
    fcw = 16'h0123;
    for (int i = 0; i < 20; i++) step("R2 short");
    do_reset();
    step("R1 after reset");
    chk(amp == 0, "R1 first sample", int'(amp), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule